// File: doc/BRIEF.md
# Rotating Calibration Channel Sequencer

This controller manages an array of N_OUT+1 converter channels that serve N_OUT signal paths. At every moment one channel is detached from signal duty and tied to a shared reference converter for calibration. The other N_OUT channels feed the outputs through a row of two-position selectors. When the calibration of the current channel is reported complete, the controller hands that channel back to signal duty and attaches the next channel in a fixed rotation to the reference.

Channels are numbered 0 to N_OUT, and selectors 0 to N_OUT-1. Selector k has two poles. Its "up" pole connects output k to channel k, and its "down" pole connects output k to channel k+1. Output k takes the up pole when k is below the index of the calibrating channel, and the down pole otherwise, so the selector row forms a thermometer code of that index. A selector that changes position first closes both poles for a programmable overlap time, then opens the old pole. During every changeover the reference isolation switches all stay open. The new channel's isolation switch closes only after the last overlap has ended.

The block moves no data stream, so all of its pins are plain level controls. `start_i` and `cal_done_i` are sampled on each rising clock edge. `cal_done_i` is acted on only while the block is settled with one channel attached to the reference.

Top module: `rotating_cal_seq`

## Requirements
- R1: While reset is held and just after it is released, the calibrating index is N_OUT, only isolation switch N_OUT is closed, every selector has only its up pole closed, and `ovl_active_o` is low.
- R2: While no overlap is active, exactly one isolation switch is closed, and its bit position equals `cal_idx_o`. While an overlap is active, every isolation switch is open.
- R3: While no overlap is active, selector k has only its up pole closed (`sel_up_o[k]`=1, `sel_dn_o[k]`=0) when k < `cal_idx_o`. Otherwise it has only its down pole closed.
- R4: `cal_done_i` has no effect until `start_i` has been seen high after reset. `cal_done_i` pulses that arrive during an overlap are also ignored, and `start_i` has no effect once the block is running.
- R5: On a non-wrapping advance from index c < N_OUT, `cal_done_i` is sampled high at an edge. From that edge on, selector c alone has both poles closed, for L cycles.
- R6: At the edge that ends the last overlap, `cal_idx_o` moves to the next index in the rotation 0,1,…,N_OUT,0. The new index's isolation switch closes at that same edge. `cal_idx_o` keeps its old value during the overlap.
- R7: On the wrap from N_OUT to 0, selectors N_OUT-1 down to 0 move from up to down one at a time, each with its own L-cycle overlap. `cal_idx_o` then becomes 0.
- R8: L is `ovl_len_i`, sampled at the edge where each overlap starts and ignored afterwards. A value of 0 is treated as 1.
- R9: Every selector has at least one pole closed at all times.
- R10: `ovl_active_o` is high exactly while one selector has both poles closed, and no more than one selector is ever in overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Enables the rotation; sampled each edge |
| cal_done_i | input | 1 | Calibration of the current channel finished |
| ovl_len_i | input | OVL_W | Overlap length in cycles (0 acts as 1) |
| iso_en_o | output | N_OUT+1 | Reference isolation switch enable per channel |
| sel_up_o | output | N_OUT | Selector k pole to channel k |
| sel_dn_o | output | N_OUT | Selector k pole to channel k+1 |
| cal_idx_o | output | $clog2(N_OUT+1) | Index of the channel under calibration |
| ovl_active_o | output | 1 | A selector is in make-before-break overlap |

## Verification
The bench first aims at the wrap from the top index, because that is the advance where every selector flips. A design that flipped all selectors together would show several selectors in overlap at once, and one that skipped the ripple would reach index 0 too early. It sends `cal_done_i` both before `start_i` and in the middle of an overlap. A design that reacted to either would step the index twice or cut the overlap short. It changes `ovl_len_i` after an overlap has begun and programs a length of zero. A design that did not sample the length at the start would stretch or shorten the overlap, and one that took zero literally would skip the overlap or wrap its counter. Each cycle is checked for isolation switches that close before the overlap has ended.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAL  = 2'd1,
    ST_OVL  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/cal_ovl_timer.sv
module cal_ovl_timer #(
  parameter int OVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [OVL_W-1:0] len_i,
  output logic             done_o
);
  logic [OVL_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= (len_i == '0) ? OVL_W'(1) : len_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = (cnt_q == OVL_W'(1));

  // R8: a zero length still yields a one-cycle window
  p_zero_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && len_i == '0) |=> done_o);
endmodule

// File: rtl/cal_rot_fsm.sv
module cal_rot_fsm
  import cal_seq_pkg::*;
#(
  parameter int N_OUT = 3,
  parameter int IDX_W = $clog2(N_OUT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cal_done_i,
  input  logic             tmr_done_i,
  output logic             tmr_load_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N_OUT-1:0] pos_o,
  output logic [IDX_W-1:0] osel_o,
  output logic             ovl_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_OUT);
  localparam logic [IDX_W-1:0] TOP_SEL  = IDX_W'(N_OUT - 1);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d, osel_q, osel_d;
  logic [N_OUT-1:0] pos_q, pos_d;
  logic             load;
  logic             wrap;

  assign wrap = (idx_q == LAST_IDX);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    osel_d  = osel_q;
    pos_d   = pos_q;
    load    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_CAL;
      ST_CAL: begin
        if (cal_done_i) begin
          state_d = ST_OVL;
          osel_d  = wrap ? TOP_SEL : idx_q;
          load    = 1'b1;
        end
      end
      ST_OVL: begin
        if (tmr_done_i) begin
          for (int k = 0; k < N_OUT; k++) begin
            if (osel_q == IDX_W'(k)) pos_d[k] = ~pos_q[k];
          end
          if (wrap && osel_q != '0) begin
            osel_d = osel_q - 1'b1;
            load   = 1'b1;
          end else begin
            state_d = ST_CAL;
            idx_d   = wrap ? '0 : idx_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= LAST_IDX;
      osel_q  <= '0;
      pos_q   <= '1;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      osel_q  <= osel_d;
      pos_q   <= pos_d;
    end
  end

  assign tmr_load_o = load;
  assign idx_o      = idx_q;
  assign pos_o      = pos_q;
  assign osel_o     = osel_q;
  assign ovl_o      = (state_q == ST_OVL);

  // R6: the index only ever steps to its rotation successor
  p_idx_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(idx_q) |-> (idx_q == (($past(idx_q) == LAST_IDX) ? '0 : $past(idx_q) + 1'b1)));
  // R6: the index never moves while an overlap continues
  p_idx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OVL && !tmr_done_i) |=> $stable(idx_q));
  // R4: no activity before the enable has been seen
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |=> (state_q != ST_OVL));
  // R7: the wrap ripple runs downward, one selector per step
  p_ripple_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OVL && $past(state_q) == ST_OVL && !$stable(osel_q))
      |-> (osel_q == $past(osel_q) - 1'b1));
endmodule

// File: rtl/cal_switch_drv.sv
module cal_switch_drv #(
  parameter int N_OUT = 3,
  parameter int IDX_W = $clog2(N_OUT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [N_OUT-1:0] pos_i,
  input  logic [IDX_W-1:0] osel_i,
  input  logic             ovl_i,
  output logic [N_OUT:0]   iso_o,
  output logic [N_OUT-1:0] up_o,
  output logic [N_OUT-1:0] dn_o
);
  for (genvar c = 0; c <= N_OUT; c++) begin : g_iso
    assign iso_o[c] = !ovl_i && (idx_i == IDX_W'(c));
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_sel
    logic both;
    assign both  = ovl_i && (osel_i == IDX_W'(k));
    assign up_o[k] = pos_i[k] | both;
    assign dn_o[k] = ~pos_i[k] | both;

    // R3: settled selector follows the thermometer of the index
    p_therm_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !ovl_i |-> (up_o[k] == (idx_i > IDX_W'(k)) && dn_o[k] == !(idx_i > IDX_W'(k))));
  end

  // R2: at most one reference switch, none during overlap
  p_iso_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(iso_o) && (ovl_i -> iso_o == '0) && (!ovl_i -> iso_o != '0));
  // R9: no output is ever left floating
  p_no_float_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (up_o | dn_o) == '1);
  // R10: overlap flag matches exactly one doubly closed selector
  p_one_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(up_o & dn_o) == (ovl_i ? 1 : 0));
  // R6: the reference switch closes as the overlap ends
  p_iso_after_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovl_i) |-> iso_o[idx_i]);
endmodule

// File: rtl/rotating_cal_seq.sv
module rotating_cal_seq #(
  parameter int N_OUT = 3,
  parameter int OVL_W = 8,
  localparam int IDX_W = $clog2(N_OUT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cal_done_i,
  input  logic [OVL_W-1:0] ovl_len_i,
  output logic [N_OUT:0]   iso_en_o,
  output logic [N_OUT-1:0] sel_up_o,
  output logic [N_OUT-1:0] sel_dn_o,
  output logic [IDX_W-1:0] cal_idx_o,
  output logic             ovl_active_o
);
  logic             tmr_load, tmr_done, ovl;
  logic [N_OUT-1:0] pos;
  logic [IDX_W-1:0] osel;

  cal_ovl_timer #(.OVL_W(OVL_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load),
    .len_i(ovl_len_i), .done_o(tmr_done)
  );

  cal_rot_fsm #(.N_OUT(N_OUT), .IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cal_done_i(cal_done_i),
    .tmr_done_i(tmr_done), .tmr_load_o(tmr_load), .idx_o(cal_idx_o),
    .pos_o(pos), .osel_o(osel), .ovl_o(ovl)
  );

  cal_switch_drv #(.N_OUT(N_OUT), .IDX_W(IDX_W)) u_drv (
    .clk(clk), .rst_n(rst_n), .idx_i(cal_idx_o), .pos_i(pos),
    .osel_i(osel), .ovl_i(ovl), .iso_o(iso_en_o),
    .up_o(sel_up_o), .dn_o(sel_dn_o)
  );

  assign ovl_active_o = ovl;
endmodule

// File: tb/rotating_cal_seq_tb_top.sv
module rotating_cal_seq_tb_top;
  localparam int N  = 3;
  localparam int LW = 8;
  localparam int IW = $clog2(N + 1);

  typedef struct packed {
    logic [N:0]    iso;
    logic [N-1:0]  up;
    logic [N-1:0]  dn;
    logic [IW-1:0] idx;
    logic          ovl;
  } snap_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          cal_done = 1'b0;
  logic [LW-1:0] ovl_len = '0;
  logic [N:0]    iso;
  logic [N-1:0]  up, dn;
  logic [IW-1:0] idx;
  logic          ovl;

  snap_t exp_q[$];
  int checks = 0;
  int fails  = 0;
  int model_idx = N;

  always #4 clk = ~clk;

  rotating_cal_seq #(.N_OUT(N), .OVL_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cal_done_i(cal_done),
    .ovl_len_i(ovl_len), .iso_en_o(iso), .sel_up_o(up), .sel_dn_o(dn),
    .cal_idx_o(idx), .ovl_active_o(ovl)
  );

  function automatic logic [N-1:0] therm(int c);
    logic [N-1:0] m;
    for (int k = 0; k < N; k++) m[k] = (k < c);
    return m;
  endfunction

  function automatic snap_t settled(int c);
    snap_t s;
    s.iso = '0; s.iso[c] = 1'b1;
    s.up = therm(c); s.dn = ~therm(c);
    s.idx = IW'(c); s.ovl = 1'b0;
    return s;
  endfunction

  function automatic snap_t overlapping(int c, int j, logic [N-1:0] pos);
    snap_t s;
    logic [N-1:0] b;
    b = '0; b[j] = 1'b1;
    s.iso = '0; s.up = pos | b; s.dn = ~pos | b;
    s.idx = IW'(c); s.ovl = 1'b1;
    return s;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops one expected snapshot per cycle while work is queued
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      snap_t e;
      e = exp_q.pop_front();
      check(e.ovl ? "R5/R7" : "R3", "selector up poles", int'(up), int'(e.up));
      check(e.ovl ? "R5/R7" : "R3", "selector down poles", int'(dn), int'(e.dn));
      check("R2", "isolation", int'(iso), int'(e.iso));
      check("R6", "cal index", int'(idx), int'(e.idx));
      check("R10", "overlap flag", int'(ovl), int'(e.ovl));
      check("R9", "no floating output", int'(up | dn), (1 << N) - 1);
    end
  end

  task automatic wait_drain();
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  // hold settled state for n cycles, optionally poking an input that must be ignored (R4)
  task automatic hold(int n, bit poke_done, bit poke_start);
    @(negedge clk);
    for (int i = 0; i < n; i++) exp_q.push_back(settled(model_idx));
    cal_done = poke_done;
    start = poke_start;
    @(negedge clk);
    cal_done = 1'b0;
    start = 1'b0;
    wait_drain();
  endtask

  // driver: one advance, pushing the predicted cycle-by-cycle picture
  task automatic advance(int len, bit disturb);
    int eff;
    int c;
    logic [N-1:0] pos;
    eff = (len == 0) ? 1 : len;
    c = model_idx;
    @(negedge clk);
    ovl_len = LW'(len);
    cal_done = 1'b1;
    if (c < N) begin
      pos = therm(c);
      for (int i = 0; i < eff; i++) exp_q.push_back(overlapping(c, c, pos));
      model_idx = c + 1;
    end else begin
      pos = '1;
      for (int j = N - 1; j >= 0; j--) begin
        for (int i = 0; i < eff; i++) exp_q.push_back(overlapping(N, j, pos));
        pos[j] = 1'b0;
      end
      model_idx = 0;
    end
    exp_q.push_back(settled(model_idx));
    @(negedge clk);
    cal_done = 1'b0;
    if (disturb) begin
      ovl_len = LW'(1);       // R8: late change must not alter this overlap
      @(negedge clk);
      cal_done = 1'b1;        // R4: pulse inside the overlap is ignored
      @(negedge clk);
      cal_done = 1'b0;
    end
    wait_drain();
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    check("R1", "reset index", int'(idx), N);
    check("R1", "reset isolation", int'(iso), 1 << N);
    check("R1", "reset up poles", int'(up), (1 << N) - 1);
    check("R1", "reset down poles", int'(dn), 0);
    check("R1", "reset overlap", int'(ovl), 0);
    rst_n = 1'b1;
    // R1 and R4: settled after release, done pulse before enable ignored
    hold(6, 1'b1, 1'b0);
    hold(2, 1'b0, 1'b1);           // enable the rotation
    advance(2, 1'b0);              // R7: wrap from the top, ripple of three
    advance(1, 1'b0);              // R5, R6: 0 -> 1, shortest overlap
    advance(0, 1'b0);              // R8: zero acts as one, 1 -> 2
    advance(6, 1'b1);              // R4, R8: 2 -> 3 with disturbances
    hold(4, 1'b0, 1'b1);           // R4: enable while running has no effect
    advance(3, 1'b0);              // R7: second wrap with longer overlaps
    advance(4, 1'b0);              // R6: 0 -> 1
    advance(2, 1'b0);              // 1 -> 2
    advance(1, 1'b0);              // 2 -> 3
    advance(0, 1'b0);              // R7, R8: wrap with zero length
    hold(3, 1'b0, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule